// File: doc/BRIEF.md
# Endpoint FIFO Pointer Controller

This block sequences eight endpoint FIFOs whose storage sits in external RAMs: four for the transmit direction and four for the receive direction. For each direction it produces one shared write address and one shared read address. It also drives one active-low write strobe per RAM, a read-RAM select, per-FIFO full and empty flags, and a per-FIFO indication that committed data is waiting. The RAMs, packet decoding and any application-bus decoding sit outside.

Each FIFO is handled from two sides. A producer writes bytes and a consumer reads them. Each side keeps a live pointer and a committed pointer. A commit makes the live pointer permanent. A rewind returns the live pointer to the committed one. This lets a failed transaction be retransmitted from the transmit side or received again on the receive side. Flags are computed only against the other side's committed pointer, so a data set that is still being built or consumed stays invisible.

The last FIFO of each direction (index 3) is the large one. It runs in two-set mode. A two-entry queue records the length of each committed data set. The consumer stops at the end of the head set, and releasing that set frees exactly its length.

Top module: `usb_ep_fifo_ctrl`

## Requirements
- R1: After reset every FIFO reports empty, not full and no ready data, all write strobes are high (inactive), and both write and read addresses are 0.
- R2: An accepted write drives low only the strobe of the FIFO selected by the write select (bit i of the strobe vector belongs to FIFO i). The shared write address equals that FIFO's live write pointer, taken modulo the FIFO depth and zero-extended. The pointer advances by one per accepted write and wraps at the depth.
- R3: The shared read address equals the live read pointer of the FIFO selected by the read select, modulo its depth. It advances by one per accepted read. The read-RAM select output equals the read select.
- R4: Bytes that are written but not committed leave empty high and ready low. After a producer commit, empty falls and ready rises.
- R5: A small FIFO is full when its live write pointer is a full depth ahead of its committed read pointer. While full, a write produces no strobe and leaves the write address unchanged.
- R6: A read while empty is ignored and leaves the read address unchanged.
- R7: A producer rewind returns the live write pointer to the committed write pointer and discards the uncommitted bytes.
- R8: A consumer rewind returns the live read pointer to the committed read pointer. A consumer commit in a small FIFO frees the space that was read, which clears full.
- R9: On each side a rewind takes priority over a commit, and a commit takes priority over a data move. A write presented in the same cycle as a commit produces no strobe and no pointer move.
- R10: In the large FIFO, a producer commit records the set length. The consumer sees empty at the end of the head set even while a second set is pending, and a read there is ignored.
- R11: In the large FIFO, full is asserted while two sets are pending and writes are then refused. A producer commit with zero new bytes records nothing.
- R12: In the large FIFO, a consumer commit releases the whole head set: both read pointers advance to the set's end, even if the set was only partly read. With no set pending the commit is ignored.
- R13: The transmit and receive directions are independent, and commands to one never change the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr_sel | input | SW | Transmit FIFO addressed by producer commands |
| tx_wr_en | input | 1 | Transmit producer write request |
| tx_wr_commit | input | 1 | Transmit producer commit |
| tx_wr_rewind | input | 1 | Transmit producer rewind |
| tx_rd_sel | input | SW | Transmit FIFO addressed by consumer commands |
| tx_rd_en | input | 1 | Transmit consumer read request |
| tx_rd_commit | input | 1 | Transmit consumer commit (set delivered) |
| tx_rd_rewind | input | 1 | Transmit consumer rewind (retransmit) |
| tx_wr_addr | output | AW | Shared transmit RAM write address |
| tx_wr_strobe_n | output | N | Active-low write strobe per transmit RAM |
| tx_rd_addr | output | AW | Shared transmit RAM read address |
| tx_rd_ram_sel | output | SW | Transmit RAM chosen for reading |
| tx_full | output | N | Full flag per transmit FIFO |
| tx_empty | output | N | Empty flag per transmit FIFO |
| tx_data_ready | output | N | Committed data present per transmit FIFO |
| rx_wr_sel | input | SW | Receive FIFO addressed by producer commands |
| rx_wr_en | input | 1 | Receive producer write request |
| rx_wr_commit | input | 1 | Receive producer commit (good packet) |
| rx_wr_rewind | input | 1 | Receive producer rewind (re-receive) |
| rx_rd_sel | input | SW | Receive FIFO addressed by consumer commands |
| rx_rd_en | input | 1 | Receive consumer read request |
| rx_rd_commit | input | 1 | Receive consumer commit |
| rx_rd_rewind | input | 1 | Receive consumer rewind |
| rx_wr_addr | output | AW | Shared receive RAM write address |
| rx_wr_strobe_n | output | N | Active-low write strobe per receive RAM |
| rx_rd_addr | output | AW | Shared receive RAM read address |
| rx_rd_ram_sel | output | SW | Receive RAM chosen for reading |
| rx_full | output | N | Full flag per receive FIFO |
| rx_empty | output | N | Empty flag per receive FIFO |
| rx_pkt_ready | output | N | Committed packet data present per receive FIFO |

## Verification
The bench builds the block with 8-entry small FIFOs (SMALL_AW=3) and a 16-entry large FIFO (LARGE_AW=4). With these sizes, address wrap and the full boundary of a small FIFO take only a few dozen writes. A 3-byte set followed by a 2-byte set makes the large FIFO hold two pending sets, so set-end emptiness, the two-set full condition and partial release can all be reached in short directed sequences. The address width is still 4 bits, so the zero-extension of the small FIFOs' addresses is observed as well.

// File: rtl/usb_fifo_pkg.sv
package usb_fifo_pkg;

    // One side's command to one FIFO after select decode and priority.
    typedef struct packed {
        logic move;
        logic commit;
        logic rewind;
    } side_cmd_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic ready;
    } fifo_flags_t;

    // Address width of FIFO idx: the large index gets the large size.
    function automatic int fifo_aw(input int idx, input int large_idx,
                                   input int small_aw, input int large_aw);
        return (idx == large_idx) ? large_aw : small_aw;
    endfunction

    // Rewind beats commit, commit beats data move.
    function automatic side_cmd_t decode_cmd(input logic hit, input logic move,
                                             input logic commit, input logic rewind);
        side_cmd_t c;
        c.rewind = hit & rewind;
        c.commit = hit & commit & ~rewind;
        c.move   = hit & move & ~commit & ~rewind;
        return c;
    endfunction

endpackage

// File: rtl/set_len_queue.sv
module set_len_queue #(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [LW-1:0] len_in,
    input  logic          pop,
    output logic [LW-1:0] head,
    output logic [1:0]    count
);

    logic [LW-1:0] q0, q1;

    always_ff @(posedge clk) begin
        if (rst) begin
            q0    <= '0;
            q1    <= '0;
            count <= 2'd0;
        end else begin
            unique case ({push, pop})
                2'b10: begin
                    if (count == 2'd0) q0 <= len_in;
                    else               q1 <= len_in;
                    count <= count + 2'd1;
                end
                2'b01: begin
                    q0    <= q1;
                    count <= count - 2'd1;
                end
                2'b11: begin
                    if (count == 2'd1) begin
                        q0 <= len_in;
                    end else begin
                        q0 <= q1;
                        q1 <= len_in;
                    end
                end
                default: ;
            endcase
        end
    end

    assign head = q0;

    // R11
    set_count_chk: assert property (@(posedge clk) disable iff (rst)
        count != 2'd3);

    // R11
    push_guard_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> count != 2'd2);

endmodule

// File: rtl/fifo_ptr_unit.sv
module fifo_ptr_unit
    import usb_fifo_pkg::*;
#(
    parameter int AW_I      = 6,
    parameter int AW        = 11,
    parameter bit TWO_LEVEL = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  side_cmd_t   wcmd,
    input  side_cmd_t   rcmd,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic        wr_fire,
    output fifo_flags_t flags
);

    localparam int PW = AW_I + 1;
    localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW_I{1'b0}}};
    localparam logic [PW-1:0] ONE_P   = PW'(1);

    logic [PW-1:0] wr_live, wr_cmt, rd_live, rd_cmt;
    logic [PW-1:0] used_w, rd_release;
    logic          p_commit_ok, c_commit_ok, rd_fire;

    assign used_w = wr_live - rd_cmt;

    generate
        if (TWO_LEVEL) begin : g_two
            logic [PW-1:0] set_len, head_len, rd_span;
            logic [1:0]    pend;

            assign set_len     = wr_live - wr_cmt;
            assign rd_span     = rd_live - rd_cmt;
            assign p_commit_ok = wcmd.commit && (pend != 2'd2) && (set_len != '0);
            assign c_commit_ok = rcmd.commit && (pend != 2'd0);
            assign flags.full  = (pend == 2'd2) || (used_w == DEPTH_P);
            assign flags.empty = (pend == 2'd0) || (rd_span == head_len);
            assign flags.ready = (pend != 2'd0);
            assign rd_release  = rd_cmt + head_len;

            set_len_queue #(.LW(PW)) u_lenq (
                .clk    (clk),
                .rst    (rst),
                .push   (p_commit_ok),
                .len_in (set_len),
                .pop    (c_commit_ok),
                .head   (head_len),
                .count  (pend)
            );

            // R10
            set_bound_chk: assert property (@(posedge clk) disable iff (rst)
                rd_fire |-> rd_span < head_len);
        end else begin : g_one
            assign p_commit_ok = wcmd.commit;
            assign c_commit_ok = rcmd.commit;
            assign flags.full  = (used_w == DEPTH_P);
            assign flags.empty = (rd_live == wr_cmt);
            assign flags.ready = (wr_cmt != rd_cmt);
            assign rd_release  = rd_live;
        end
    endgenerate

    assign wr_fire = wcmd.move && !flags.full;
    assign rd_fire = rcmd.move && !flags.empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_live <= '0;
            wr_cmt  <= '0;
            rd_live <= '0;
            rd_cmt  <= '0;
        end else begin
            if (wcmd.rewind)      wr_live <= wr_cmt;
            else if (p_commit_ok) wr_cmt  <= wr_live;
            else if (wr_fire)     wr_live <= wr_live + ONE_P;

            if (rcmd.rewind) begin
                rd_live <= rd_cmt;
            end else if (c_commit_ok) begin
                rd_cmt  <= rd_release;
                rd_live <= rd_release;
            end else if (rd_fire) begin
                rd_live <= rd_live + ONE_P;
            end
        end
    end

    assign waddr = AW'(wr_live[AW_I-1:0]);
    assign raddr = AW'(rd_live[AW_I-1:0]);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wcmd.move && flags.full) |=> $stable(wr_live));

    // R5
    occupancy_chk: assert property (@(posedge clk) disable iff (rst)
        used_w <= DEPTH_P);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (rcmd.move && flags.empty) |=> $stable(rd_live));

    // R7
    wr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        wcmd.rewind |=> wr_live == $past(wr_cmt));

    // R8
    rd_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        rcmd.rewind |=> rd_live == $past(rd_cmt));

endmodule

// File: rtl/fifo_bank.sv
module fifo_bank
    import usb_fifo_pkg::*;
#(
    parameter int N         = 4,
    parameter int SMALL_AW  = 6,
    parameter int LARGE_AW  = 11,
    parameter int LARGE_IDX = 3,
    parameter int SW        = 2,
    parameter int AW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] wr_sel,
    input  logic          wr_en,
    input  logic          wr_commit,
    input  logic          wr_rewind,
    input  logic [SW-1:0] rd_sel,
    input  logic          rd_en,
    input  logic          rd_commit,
    input  logic          rd_rewind,
    output logic [AW-1:0] wr_addr,
    output logic [N-1:0]  wr_strobe_n,
    output logic [AW-1:0] rd_addr,
    output logic [SW-1:0] rd_ram_sel,
    output logic [N-1:0]  full,
    output logic [N-1:0]  empty,
    output logic [N-1:0]  ready
);

    logic [AW-1:0] waddr_a [N];
    logic [AW-1:0] raddr_a [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_fifo
            side_cmd_t   wc, rc;
            fifo_flags_t flg;
            logic        fire;

            assign wc = decode_cmd(wr_sel == SW'(g), wr_en, wr_commit, wr_rewind);
            assign rc = decode_cmd(rd_sel == SW'(g), rd_en, rd_commit, rd_rewind);

            fifo_ptr_unit #(
                .AW_I      (fifo_aw(g, LARGE_IDX, SMALL_AW, LARGE_AW)),
                .AW        (AW),
                .TWO_LEVEL (g == LARGE_IDX)
            ) u_unit (
                .clk     (clk),
                .rst     (rst),
                .wcmd    (wc),
                .rcmd    (rc),
                .waddr   (waddr_a[g]),
                .raddr   (raddr_a[g]),
                .wr_fire (fire),
                .flags   (flg)
            );

            assign wr_strobe_n[g] = ~fire;
            assign full[g]        = flg.full;
            assign empty[g]       = flg.empty;
            assign ready[g]       = flg.ready;
        end
    endgenerate

    assign wr_addr    = waddr_a[wr_sel];
    assign rd_addr    = raddr_a[rd_sel];
    assign rd_ram_sel = rd_sel;

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~wr_strobe_n));

endmodule

// File: rtl/usb_ep_fifo_ctrl.sv
module usb_ep_fifo_ctrl #(
    parameter int N         = 4,
    parameter int SMALL_AW  = 6,
    parameter int LARGE_AW  = 11,
    parameter int LARGE_IDX = 3,
    localparam int SW       = $clog2(N),
    localparam int AW       = LARGE_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] tx_wr_sel,
    input  logic          tx_wr_en,
    input  logic          tx_wr_commit,
    input  logic          tx_wr_rewind,
    input  logic [SW-1:0] tx_rd_sel,
    input  logic          tx_rd_en,
    input  logic          tx_rd_commit,
    input  logic          tx_rd_rewind,
    output logic [AW-1:0] tx_wr_addr,
    output logic [N-1:0]  tx_wr_strobe_n,
    output logic [AW-1:0] tx_rd_addr,
    output logic [SW-1:0] tx_rd_ram_sel,
    output logic [N-1:0]  tx_full,
    output logic [N-1:0]  tx_empty,
    output logic [N-1:0]  tx_data_ready,
    input  logic [SW-1:0] rx_wr_sel,
    input  logic          rx_wr_en,
    input  logic          rx_wr_commit,
    input  logic          rx_wr_rewind,
    input  logic [SW-1:0] rx_rd_sel,
    input  logic          rx_rd_en,
    input  logic          rx_rd_commit,
    input  logic          rx_rd_rewind,
    output logic [AW-1:0] rx_wr_addr,
    output logic [N-1:0]  rx_wr_strobe_n,
    output logic [AW-1:0] rx_rd_addr,
    output logic [SW-1:0] rx_rd_ram_sel,
    output logic [N-1:0]  rx_full,
    output logic [N-1:0]  rx_empty,
    output logic [N-1:0]  rx_pkt_ready
);

    fifo_bank #(
        .N(N), .SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW),
        .LARGE_IDX(LARGE_IDX), .SW(SW), .AW(AW)
    ) u_tx (
        .clk         (clk),
        .rst         (rst),
        .wr_sel      (tx_wr_sel),
        .wr_en       (tx_wr_en),
        .wr_commit   (tx_wr_commit),
        .wr_rewind   (tx_wr_rewind),
        .rd_sel      (tx_rd_sel),
        .rd_en       (tx_rd_en),
        .rd_commit   (tx_rd_commit),
        .rd_rewind   (tx_rd_rewind),
        .wr_addr     (tx_wr_addr),
        .wr_strobe_n (tx_wr_strobe_n),
        .rd_addr     (tx_rd_addr),
        .rd_ram_sel  (tx_rd_ram_sel),
        .full        (tx_full),
        .empty       (tx_empty),
        .ready       (tx_data_ready)
    );

    fifo_bank #(
        .N(N), .SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW),
        .LARGE_IDX(LARGE_IDX), .SW(SW), .AW(AW)
    ) u_rx (
        .clk         (clk),
        .rst         (rst),
        .wr_sel      (rx_wr_sel),
        .wr_en       (rx_wr_en),
        .wr_commit   (rx_wr_commit),
        .wr_rewind   (rx_wr_rewind),
        .rd_sel      (rx_rd_sel),
        .rd_en       (rx_rd_en),
        .rd_commit   (rx_rd_commit),
        .rd_rewind   (rx_rd_rewind),
        .wr_addr     (rx_wr_addr),
        .wr_strobe_n (rx_wr_strobe_n),
        .rd_addr     (rx_rd_addr),
        .rd_ram_sel  (rx_rd_ram_sel),
        .full        (rx_full),
        .empty       (rx_empty),
        .ready       (rx_pkt_ready)
    );

endmodule

// File: tb/usb_ep_fifo_ctrl_test.sv
module usb_ep_fifo_ctrl_test;

    localparam int N = 4, SW = 2, AW = 4;

    localparam logic [2:0] OP_WR = 3'd0, OP_WC = 3'd1, OP_WRW = 3'd2,
                           OP_RD = 3'd3, OP_RC = 3'd4, OP_RRW = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SW-1:0] tx_wr_sel = '0, tx_rd_sel = '0, rx_wr_sel = '0, rx_rd_sel = '0;
    logic tx_wr_en = 0, tx_wr_commit = 0, tx_wr_rewind = 0;
    logic tx_rd_en = 0, tx_rd_commit = 0, tx_rd_rewind = 0;
    logic rx_wr_en = 0, rx_wr_commit = 0, rx_wr_rewind = 0;
    logic rx_rd_en = 0, rx_rd_commit = 0, rx_rd_rewind = 0;
    logic [AW-1:0] tx_wr_addr, tx_rd_addr, rx_wr_addr, rx_rd_addr;
    logic [N-1:0]  tx_wr_strobe_n, tx_full, tx_empty, tx_data_ready;
    logic [N-1:0]  rx_wr_strobe_n, rx_full, rx_empty, rx_pkt_ready;
    logic [SW-1:0] tx_rd_ram_sel, rx_rd_ram_sel;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    usb_ep_fifo_ctrl #(.N(4), .SMALL_AW(3), .LARGE_AW(4), .LARGE_IDX(3)) uut (
        .clk(clk), .rst(rst),
        .tx_wr_sel(tx_wr_sel), .tx_wr_en(tx_wr_en), .tx_wr_commit(tx_wr_commit),
        .tx_wr_rewind(tx_wr_rewind), .tx_rd_sel(tx_rd_sel), .tx_rd_en(tx_rd_en),
        .tx_rd_commit(tx_rd_commit), .tx_rd_rewind(tx_rd_rewind),
        .tx_wr_addr(tx_wr_addr), .tx_wr_strobe_n(tx_wr_strobe_n),
        .tx_rd_addr(tx_rd_addr), .tx_rd_ram_sel(tx_rd_ram_sel),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_data_ready(tx_data_ready),
        .rx_wr_sel(rx_wr_sel), .rx_wr_en(rx_wr_en), .rx_wr_commit(rx_wr_commit),
        .rx_wr_rewind(rx_wr_rewind), .rx_rd_sel(rx_rd_sel), .rx_rd_en(rx_rd_en),
        .rx_rd_commit(rx_rd_commit), .rx_rd_rewind(rx_rd_rewind),
        .rx_wr_addr(rx_wr_addr), .rx_wr_strobe_n(rx_wr_strobe_n),
        .rx_rd_addr(rx_rd_addr), .rx_rd_ram_sel(rx_rd_ram_sel),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_pkt_ready(rx_pkt_ready)
    );

    // Table rows for transmit FIFO 1 (depth 8): {op, wr_addr, rd_addr, empty, full, ready}
    localparam int TAB_LEN = 27;
    localparam logic [13:0] TX_TAB [TAB_LEN] = '{
        {OP_WR,  4'd1, 4'd0, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd2, 4'd0, 1'b1, 1'b0, 1'b0},
        {OP_WRW, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0},   // R7 producer rewind
        {OP_WR,  4'd1, 4'd0, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd2, 4'd0, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd3, 4'd0, 1'b1, 1'b0, 1'b0},
        {OP_WC,  4'd3, 4'd0, 1'b0, 1'b0, 1'b1},
        {OP_RD,  4'd3, 4'd1, 1'b0, 1'b0, 1'b1},
        {OP_RD,  4'd3, 4'd2, 1'b0, 1'b0, 1'b1},
        {OP_RRW, 4'd3, 4'd0, 1'b0, 1'b0, 1'b1},   // R8 consumer rewind
        {OP_RD,  4'd3, 4'd1, 1'b0, 1'b0, 1'b1},
        {OP_RD,  4'd3, 4'd2, 1'b0, 1'b0, 1'b1},
        {OP_RD,  4'd3, 4'd3, 1'b1, 1'b0, 1'b1},
        {OP_RD,  4'd3, 4'd3, 1'b1, 1'b0, 1'b1},   // R6 read while empty
        {OP_RC,  4'd3, 4'd3, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd4, 4'd3, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd5, 4'd3, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd6, 4'd3, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd7, 4'd3, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd0, 4'd3, 1'b1, 1'b0, 1'b0},   // R2 wrap
        {OP_WR,  4'd1, 4'd3, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd2, 4'd3, 1'b1, 1'b0, 1'b0},
        {OP_WR,  4'd3, 4'd3, 1'b1, 1'b1, 1'b0},   // R5 full boundary
        {OP_WR,  4'd3, 4'd3, 1'b1, 1'b1, 1'b0},   // R5 write refused
        {OP_WC,  4'd3, 4'd3, 1'b0, 1'b1, 1'b1},
        {OP_RD,  4'd3, 4'd4, 1'b0, 1'b1, 1'b1},
        {OP_RC,  4'd3, 4'd4, 1'b0, 1'b0, 1'b1}    // R8 commit frees space
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic tx_step(input logic [2:0] op);
        tx_wr_en     = (op == OP_WR);
        tx_wr_commit = (op == OP_WC);
        tx_wr_rewind = (op == OP_WRW);
        tx_rd_en     = (op == OP_RD);
        tx_rd_commit = (op == OP_RC);
        tx_rd_rewind = (op == OP_RRW);
        @(posedge clk);
        @(negedge clk);
        {tx_wr_en, tx_wr_commit, tx_wr_rewind, tx_rd_en, tx_rd_commit, tx_rd_rewind} = '0;
        #1;
    endtask

    task automatic rx_step(input logic [2:0] op);
        rx_wr_en     = (op == OP_WR);
        rx_wr_commit = (op == OP_WC);
        rx_wr_rewind = (op == OP_WRW);
        rx_rd_en     = (op == OP_RD);
        rx_rd_commit = (op == OP_RC);
        rx_rd_rewind = (op == OP_RRW);
        @(posedge clk);
        @(negedge clk);
        {rx_wr_en, rx_wr_commit, rx_wr_rewind, rx_rd_en, rx_rd_commit, rx_rd_rewind} = '0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 tx_empty", int'(tx_empty), 15);
        chk("R1 rx_empty", int'(rx_empty), 15);
        chk("R1 full", int'({tx_full, rx_full}), 0);
        chk("R1 ready", int'({tx_data_ready, rx_pkt_ready}), 0);
        chk("R1 strobes", int'({tx_wr_strobe_n, rx_wr_strobe_n}), 255);
        chk("R1 addresses", int'({tx_wr_addr, tx_rd_addr, rx_wr_addr, rx_rd_addr}), 0);

        // Table walk on transmit FIFO 1
        tx_wr_sel = 2'd1;
        tx_rd_sel = 2'd1;
        for (int i = 0; i < TAB_LEN; i++) begin
            tx_step(TX_TAB[i][13:11]);
            chk("R2 wr_addr", int'(tx_wr_addr), int'(TX_TAB[i][10:7]));
            chk("R3 rd_addr", int'(tx_rd_addr), int'(TX_TAB[i][6:3]));
            chk("R4 empty", int'(tx_empty[1]), int'(TX_TAB[i][2]));
            chk("R5 full", int'(tx_full[1]), int'(TX_TAB[i][1]));
            chk("R4 ready", int'(tx_data_ready[1]), int'(TX_TAB[i][0]));
        end

        // R13 the receive side is untouched by transmit traffic
        chk("R13 rx_empty", int'(rx_empty), 15);
        chk("R13 rx_pkt_ready", int'(rx_pkt_ready), 0);
        chk("R13 tx_empty others", int'(tx_empty), 13);

        // R2 strobe select for receive FIFO 2
        rx_wr_sel = 2'd2;
        rx_wr_en  = 1'b1;
        #1;
        chk("R2 rx strobe", int'(rx_wr_strobe_n), 11);
        chk("R13 tx strobe idle", int'(tx_wr_strobe_n), 15);
        chk("R2 rx wr_addr", int'(rx_wr_addr), 0);
        rx_step(OP_WR);
        chk("R2 rx wr_addr advance", int'(rx_wr_addr), 1);

        // R9 write plus commit in one cycle: commit wins, no strobe
        rx_wr_en     = 1'b1;
        rx_wr_commit = 1'b1;
        #1;
        chk("R9 strobe blocked", int'(rx_wr_strobe_n), 15);
        @(posedge clk);
        @(negedge clk);
        rx_wr_en = 1'b0;
        rx_wr_commit = 1'b0;
        #1;
        chk("R9 wr_addr held", int'(rx_wr_addr), 1);
        chk("R9 commit took effect", int'(rx_pkt_ready), 4);
        rx_rd_sel = 2'd2;
        #1;
        chk("R3 rd_ram_sel", int'(rx_rd_ram_sel), 2);

        // Two-set operation on receive FIFO 3 (depth 16)
        rx_wr_sel = 2'd3;
        rx_rd_sel = 2'd3;
        #1;
        repeat (3) rx_step(OP_WR);
        rx_step(OP_WC);
        repeat (2) rx_step(OP_WR);
        rx_step(OP_WC);
        chk("R11 full two sets", int'(rx_full[3]), 1);
        chk("R10 wr_addr", int'(rx_wr_addr), 5);
        chk("R10 ready", int'(rx_pkt_ready[3]), 1);
        rx_wr_en = 1'b1;
        #1;
        chk("R11 strobe refused", int'(rx_wr_strobe_n[3]), 1);
        rx_step(OP_WR);
        chk("R11 wr_addr held", int'(rx_wr_addr), 5);

        repeat (3) rx_step(OP_RD);
        chk("R10 rd_addr at set end", int'(rx_rd_addr), 3);
        chk("R10 empty at set end", int'(rx_empty[3]), 1);
        rx_step(OP_RD);
        chk("R10 read ignored", int'(rx_rd_addr), 3);

        rx_step(OP_RC);
        chk("R12 release head rd_addr", int'(rx_rd_addr), 3);
        chk("R12 second set visible", int'(rx_empty[3]), 0);
        chk("R12 full cleared", int'(rx_full[3]), 0);
        rx_step(OP_RD);
        chk("R12 partial read", int'(rx_rd_addr), 4);
        rx_step(OP_RC);
        chk("R12 partial release", int'(rx_rd_addr), 5);
        chk("R12 empty after release", int'(rx_empty[3]), 1);
        chk("R12 ready after release", int'(rx_pkt_ready[3]), 0);
        rx_step(OP_RC);
        chk("R12 commit with no set", int'(rx_rd_addr), 5);

        rx_step(OP_WC);
        chk("R11 zero-length commit", int'(rx_pkt_ready[3]), 0);
        rx_step(OP_WR);
        rx_step(OP_WC);
        chk("R11 later commit", int'(rx_pkt_ready[3]), 1);
        chk("R11 wr_addr", int'(rx_wr_addr), 6);

        summary();
    end

endmodule